// File: doc/BRIEF.md
# Spanning-Tree Port Forwarding Filter

This block makes the final per-frame forwarding decision for a small switch with two network ports and one processor port. For every frame it receives the ingress port identifier, the outcome of an address lookup (a hit flag, an override flag and a destination mask), the mask from dynamic address resolution, and a flag that marks frames the processor injects with a tail tag. It combines these with three control bits per network port (transmit enable, receive enable, learning disable) and produces the egress port mask and a strobe that allows source-address learning.

The control bits carry the spanning-tree port state. Disabled, blocking and listening ports all clear both enables and set learning disable. A learning port clears both enables and clears learning disable. A forwarding port sets both enables and clears learning disable. The enables do not reduce to a plain pass-or-drop rule. A frame that arrives on a port whose receive is off still reaches the processor when it hits an override entry. A frame that the processor tags for a network port reaches that port even when the port's transmit is off.

The decision is registered. It appears one cycle after the per-frame strobe, and it uses the control bits as they stood at that strobe.

Top module: `stp_fwd_filter`

## Requirements
- R1: Port identifiers are 1 and 2 for the network ports and 3 for the processor port. Mask bit k-1 stands for port k, so bit 2 is the processor. The decision appears with dec_valid exactly one clock after a cycle with frm_valid high. In every cycle without a decision, dec_mask is 0 and dec_learn is 0.
- R2: A frame from a network port whose receive enable is 0, and which does not hit a lookup entry with the override flag set, gets an all-zero mask.
- R3: A frame from a network port whose receive enable is 0, and which hits a lookup entry with the override flag set, gets mask 3'b100 (processor only). The lookup mask has no effect on this.
- R4: For frames that are not tail-tag injections, each network egress bit whose transmit enable is 0 is cleared. The processor egress bit is never cleared by a transmit setting.
- R5: The ingress port's own bit is always 0 in the output mask.
- R6: A frame from port 3 with the tail-tag flag set gets mask tag_mask & 3'b011, whatever the transmit enables are. The lookup and dynamic masks are ignored.
- R7: The tail-tag flag has no effect on a frame whose ingress is port 1 or port 2.
- R8: dec_learn is high for a frame from network port k exactly when learning disable of port k is 0, so a port in the learning state learns while forwarding stays blocked. A frame from port 3 always learns.
- R9: On a normal path the destination mask is lkp_mask when lkp_hit is 1 and dyn_mask otherwise.
- R10: A frame with ingress identifier 0 gets mask 0 and learn 0.
- R11: A change to the control bits after the strobe edge does not alter the decision of the frame taken at that edge.
- R12: While reset is active and in the first cycle after it, dec_valid, dec_mask and dec_learn are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tx_en | input | NUM_NET | Transmit enable per network port (bit k-1 = port k) |
| cfg_rx_en | input | NUM_NET | Receive enable per network port |
| cfg_learn_dis | input | NUM_NET | Learning disable per network port |
| frm_valid | input | 1 | Per-frame decision strobe |
| frm_src_id | input | PID_W | Ingress port identifier |
| lkp_hit | input | 1 | Static lookup hit |
| lkp_override | input | 1 | Override flag of the hit entry |
| lkp_mask | input | NUM_NET+1 | Destination mask of the hit entry |
| dyn_mask | input | NUM_NET+1 | Destination mask from dynamic resolution |
| tag_flag | input | 1 | Frame carries a processor tail tag |
| tag_mask | input | NUM_NET+1 | Destinations named by the tail tag |
| dec_valid | output | 1 | Decision valid |
| dec_mask | output | NUM_NET+1 | Final egress mask |
| dec_learn | output | 1 | Source-address learning allowed |

## Verification
The block holds only the registered decision, so a wrong internal value shows up at the ports in the very next cycle as a wrong mask bit or learn strobe for that frame. The riskiest faults are a path selection that confuses the override and inject cases, or a transmit gate applied to the wrong bit. Either one shows up only under a specific mix of port state, ingress port and lookup flags. For that reason the bench walks each network port through all five spanning-tree states and sends each frame class in every state.

// File: rtl/stp_filter_pkg.sv
package stp_filter_pkg;

    typedef enum logic [1:0] {
        PATH_DROP     = 2'd0,
        PATH_OVERRIDE = 2'd1,
        PATH_INJECT   = 2'd2,
        PATH_NORMAL   = 2'd3
    } fwd_path_e;

endpackage

// File: rtl/stp_ingress_decode.sv
module stp_ingress_decode
    import stp_filter_pkg::*;
#(
    parameter int NUM_NET = 2,
    parameter int PID_W   = 2
) (
    input  logic [PID_W-1:0]   src_id,
    input  logic [NUM_NET-1:0] rx_en,
    input  logic [NUM_NET-1:0] learn_dis,
    input  logic               tag_flag,
    input  logic               hit,
    input  logic               override,
    output logic [NUM_NET:0]   src_oh,
    output fwd_path_e          path,
    output logic               learn_ok
);

    localparam int CPU_ID = NUM_NET + 1;

    always_comb begin
        src_oh   = '0;
        path     = PATH_DROP;
        learn_ok = 1'b0;
        for (int i = 0; i < NUM_NET; i++) begin
            if (src_id == PID_W'(i + 1)) begin
                src_oh[i] = 1'b1;
                learn_ok  = !learn_dis[i];
                if (rx_en[i]) begin
                    path = PATH_NORMAL;
                end else if (hit && override) begin
                    path = PATH_OVERRIDE;
                end else begin
                    path = PATH_DROP;
                end
            end
        end
        if (src_id == PID_W'(CPU_ID)) begin
            src_oh[NUM_NET] = 1'b1;
            learn_ok        = 1'b1;
            path            = tag_flag ? PATH_INJECT : PATH_NORMAL;
        end
    end

endmodule

// File: rtl/stp_egress_gate.sv
module stp_egress_gate
    import stp_filter_pkg::*;
#(
    parameter bit IS_CPU = 1'b0
) (
    input  fwd_path_e path,
    input  logic      dest_bit,
    input  logic      tx_ok,
    input  logic      self_bit,
    output logic      fwd
);

    always_comb begin
        unique case (path)
            PATH_DROP:     fwd = 1'b0;
            PATH_OVERRIDE: fwd = IS_CPU;
            PATH_INJECT:   fwd = IS_CPU ? 1'b0 : dest_bit;
            PATH_NORMAL:   fwd = dest_bit && tx_ok && !self_bit;
            default:       fwd = 1'b0;
        endcase
    end

endmodule

// File: rtl/stp_fwd_filter.sv
module stp_fwd_filter
    import stp_filter_pkg::*;
#(
    parameter  int NUM_NET   = 2,
    localparam int NUM_PORTS = NUM_NET + 1,
    localparam int PID_W     = $clog2(NUM_NET + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_NET-1:0]   cfg_tx_en,
    input  logic [NUM_NET-1:0]   cfg_rx_en,
    input  logic [NUM_NET-1:0]   cfg_learn_dis,
    input  logic                 frm_valid,
    input  logic [PID_W-1:0]     frm_src_id,
    input  logic                 lkp_hit,
    input  logic                 lkp_override,
    input  logic [NUM_PORTS-1:0] lkp_mask,
    input  logic [NUM_PORTS-1:0] dyn_mask,
    input  logic                 tag_flag,
    input  logic [NUM_PORTS-1:0] tag_mask,
    output logic                 dec_valid,
    output logic [NUM_PORTS-1:0] dec_mask,
    output logic                 dec_learn
);

    typedef struct packed {
        logic                 valid;
        logic [NUM_PORTS-1:0] mask;
        logic                 learn;
    } dec_state_t;

    dec_state_t st_d, st_q;

    logic [NUM_PORTS-1:0] src_oh;
    fwd_path_e            path;
    logic                 learn_ok;
    logic [NUM_PORTS-1:0] dest_sel;
    logic [NUM_PORTS-1:0] tx_ok;
    logic [NUM_PORTS-1:0] gate_out;

    stp_ingress_decode #(
        .NUM_NET (NUM_NET),
        .PID_W   (PID_W)
    ) i_ingress (
        .src_id    (frm_src_id),
        .rx_en     (cfg_rx_en),
        .learn_dis (cfg_learn_dis),
        .tag_flag  (tag_flag),
        .hit       (lkp_hit),
        .override  (lkp_override),
        .src_oh    (src_oh),
        .path      (path),
        .learn_ok  (learn_ok)
    );

    always_comb begin
        if (path == PATH_INJECT) begin
            dest_sel = tag_mask;
        end else if (lkp_hit) begin
            dest_sel = lkp_mask;
        end else begin
            dest_sel = dyn_mask;
        end
        tx_ok = {1'b1, cfg_tx_en};
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_egress
        stp_egress_gate #(
            .IS_CPU (g == NUM_NET)
        ) i_gate (
            .path     (path),
            .dest_bit (dest_sel[g]),
            .tx_ok    (tx_ok[g]),
            .self_bit (src_oh[g]),
            .fwd      (gate_out[g])
        );
    end

    always_comb begin
        st_d       = '0;
        st_d.valid = frm_valid;
        if (frm_valid) begin
            st_d.mask  = gate_out;
            st_d.learn = learn_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_valid = st_q.valid;
    assign dec_mask  = st_q.mask;
    assign dec_learn = st_q.learn;

endmodule

// File: rtl/stp_fwd_filter_chk.sv
module stp_fwd_filter_chk #(
    parameter  int NUM_NET   = 2,
    localparam int NUM_PORTS = NUM_NET + 1,
    localparam int PID_W     = $clog2(NUM_NET + 2)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_NET-1:0]   cfg_tx_en,
    input logic [NUM_NET-1:0]   cfg_rx_en,
    input logic [NUM_NET-1:0]   cfg_learn_dis,
    input logic                 frm_valid,
    input logic [PID_W-1:0]     frm_src_id,
    input logic                 lkp_hit,
    input logic                 lkp_override,
    input logic [NUM_PORTS-1:0] lkp_mask,
    input logic [NUM_PORTS-1:0] dyn_mask,
    input logic                 tag_flag,
    input logic [NUM_PORTS-1:0] tag_mask,
    input logic                 dec_valid,
    input logic [NUM_PORTS-1:0] dec_mask,
    input logic                 dec_learn
);

    localparam logic [NUM_PORTS-1:0] CPU_BIT  = NUM_PORTS'(1) << NUM_NET;
    localparam logic [NUM_PORTS-1:0] NET_BITS = ~CPU_BIT;

    logic [NUM_PORTS-1:0] c_src_oh;
    logic                 c_is_net, c_is_cpu, c_rx_off, c_ldis;

    always_comb begin
        c_src_oh = '0;
        c_rx_off = 1'b0;
        c_ldis   = 1'b0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (frm_src_id == PID_W'(i + 1)) c_src_oh[i] = 1'b1;
        end
        for (int i = 0; i < NUM_NET; i++) begin
            if (c_src_oh[i]) begin
                c_rx_off = !cfg_rx_en[i];
                c_ldis   = cfg_learn_dis[i];
            end
        end
        c_is_cpu = c_src_oh[NUM_NET];
        c_is_net = |c_src_oh[NUM_NET-1:0];
    end

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> dec_valid);

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> (!dec_valid && dec_mask == '0 && !dec_learn));

    p_rx_off_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && c_is_net && c_rx_off && !(lkp_hit && lkp_override))
        |=> dec_mask == '0);

    p_override_cpu_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && c_is_net && c_rx_off && lkp_hit && lkp_override)
        |=> dec_mask == CPU_BIT);

    p_tx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !(c_is_cpu && tag_flag))
        |=> (dec_mask[NUM_NET-1:0] & ~$past(cfg_tx_en)) == '0);

    p_no_self_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> (dec_mask & $past(c_src_oh)) == '0);

    p_inject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && c_is_cpu && tag_flag)
        |=> dec_mask == ($past(tag_mask) & NET_BITS));

    p_learn_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && c_is_net && c_ldis) |=> !dec_learn);

    p_unknown_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !c_is_net && !c_is_cpu) |=> (dec_mask == '0 && !dec_learn));

endmodule

bind stp_fwd_filter stp_fwd_filter_chk #(.NUM_NET(NUM_NET)) i_chk (.*);

// File: tb/test_stp_fwd_filter.sv
module test_stp_fwd_filter;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_tx_en = '0, cfg_rx_en = '0, cfg_learn_dis = '0;
    logic       frm_valid = 1'b0;
    logic [1:0] frm_src_id = '0;
    logic       lkp_hit = 1'b0, lkp_override = 1'b0, tag_flag = 1'b0;
    logic [2:0] lkp_mask = '0, dyn_mask = '0, tag_mask = '0;
    logic       dec_valid, dec_learn;
    logic [2:0] dec_mask;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [2:0] mask;
        logic       learn;
        string      req;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    stp_fwd_filter i_stp_fwd_filter (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_tx_en     (cfg_tx_en),
        .cfg_rx_en     (cfg_rx_en),
        .cfg_learn_dis (cfg_learn_dis),
        .frm_valid     (frm_valid),
        .frm_src_id    (frm_src_id),
        .lkp_hit       (lkp_hit),
        .lkp_override  (lkp_override),
        .lkp_mask      (lkp_mask),
        .dyn_mask      (dyn_mask),
        .tag_flag      (tag_flag),
        .tag_mask      (tag_mask),
        .dec_valid     (dec_valid),
        .dec_mask      (dec_mask),
        .dec_learn     (dec_learn)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model built from the requirements: returns {learn, mask}.
    function automatic logic [3:0] ref_model(
        input logic [1:0] tx, input logic [1:0] rx, input logic [1:0] ld,
        input logic [1:0] src, input logic hit, input logic ovr,
        input logic [2:0] lm, input logic [2:0] dm,
        input logic tag, input logic [2:0] tm);
        logic [2:0] dest, m;
        logic       l;
        int         k;
        dest = hit ? lm : dm;
        m = 3'b000;
        l = 1'b0;
        if (src == 2'd3) begin
            l = 1'b1;
            if (tag) m = tm & 3'b011;
            else     m = dest & {1'b1, tx} & 3'b011;
        end else if (src == 2'd1 || src == 2'd2) begin
            k = int'(src) - 1;
            l = !ld[k];
            if (rx[k])            m = dest & {1'b1, tx} & ~(3'b001 << k);
            else if (hit && ovr)  m = 3'b100;
            else                  m = 3'b000;
        end
        return {l, m};
    endfunction

    task automatic send(input logic [1:0] src, input logic hit, input logic ovr,
                        input logic [2:0] lm, input logic [2:0] dm,
                        input logic tag, input logic [2:0] tm,
                        input bit flip_cfg, input string req);
        logic [3:0] e;
        exp_t       it;
        @(negedge clk);
        frm_src_id   = src;
        lkp_hit      = hit;
        lkp_override = ovr;
        lkp_mask     = lm;
        dyn_mask     = dm;
        tag_flag     = tag;
        tag_mask     = tm;
        frm_valid    = 1'b1;
        e = ref_model(cfg_tx_en, cfg_rx_en, cfg_learn_dis, src, hit, ovr, lm, dm, tag, tm);
        it.mask  = e[2:0];
        it.learn = e[3];
        it.req   = req;
        sb_q.push_back(it);
        if (flip_cfg) begin
            @(posedge clk);
            #1;
            cfg_tx_en     = ~cfg_tx_en;
            cfg_rx_en     = ~cfg_rx_en;
            cfg_learn_dis = ~cfg_learn_dis;
        end
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    // Monitor: pops the expected decision whenever one is presented.
    always @(negedge clk) begin
        if (rst_n && dec_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R1", "unexpected decision", 1, 0);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                check(dec_mask == it.mask, it.req, "mask", int'(dec_mask), int'(it.mask));
                check(dec_learn == it.learn, it.req, "learn", int'(dec_learn), int'(it.learn));
            end
        end
    end

    task automatic set_state(input int p, input int st);
        case (st)
            0, 1, 2: begin cfg_tx_en[p] = 1'b0; cfg_rx_en[p] = 1'b0; cfg_learn_dis[p] = 1'b1; end
            3:       begin cfg_tx_en[p] = 1'b0; cfg_rx_en[p] = 1'b0; cfg_learn_dis[p] = 1'b0; end
            default: begin cfg_tx_en[p] = 1'b1; cfg_rx_en[p] = 1'b1; cfg_learn_dis[p] = 1'b0; end
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog", "timeout", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: outputs cleared during reset
        check(dec_valid == 1'b0 && dec_mask == 3'b0 && dec_learn == 1'b0, "R12",
              "reset outputs", int'({dec_valid, dec_mask, dec_learn}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dec_valid == 1'b0 && dec_mask == 3'b0, "R12", "post-reset outputs",
              int'({dec_valid, dec_mask}), 0);

        // Walk every spanning-tree state on each network port.
        for (int p = 0; p < 2; p++) begin
            for (int st = 0; st < 5; st++) begin
                set_state(p, st);
                set_state(1 - p, 4);
                // R2/R5/R8: flood from the port under test
                send(2'(p + 1), 1'b0, 1'b0, 3'b000, 3'b111, 1'b0, 3'b000, 1'b0, "R2_R5_R8");
                // R3: override hit with a lookup mask that excludes the processor
                send(2'(p + 1), 1'b1, 1'b1, 3'b011, 3'b000, 1'b0, 3'b000, 1'b0, "R3");
                // R2: hit without override still dropped when receive is off
                send(2'(p + 1), 1'b1, 1'b0, 3'b111, 3'b000, 1'b0, 3'b000, 1'b0, "R2");
                // R4: frame from the other port towards the port under test
                send(2'(2 - p), 1'b1, 1'b0, 3'b111, 3'b000, 1'b0, 3'b000, 1'b0, "R4");
                // R6: processor injection towards the port under test
                send(2'd3, 1'b0, 1'b0, 3'b000, 3'b000, 1'b1, 3'(3'b001 << p) | 3'b100,
                     1'b0, "R6");
                // R4/R5: untagged processor frame, flood
                send(2'd3, 1'b0, 1'b0, 3'b000, 3'b111, 1'b0, 3'b000, 1'b0, "R4_R5");
            end
        end

        set_state(0, 4);
        set_state(1, 4);
        // R7: tag flag on a network ingress is ignored
        send(2'd1, 1'b0, 1'b0, 3'b000, 3'b100, 1'b1, 3'b010, 1'b0, "R7");
        // R9: hit picks the lookup mask, miss picks the dynamic mask
        send(2'd1, 1'b1, 1'b0, 3'b010, 3'b100, 1'b0, 3'b000, 1'b0, "R9");
        send(2'd1, 1'b0, 1'b0, 3'b010, 3'b100, 1'b0, 3'b000, 1'b0, "R9");
        // R10: unknown ingress identifier
        send(2'd0, 1'b1, 1'b1, 3'b111, 3'b111, 1'b1, 3'b111, 1'b0, "R10");
        // R6: injection with lookup and dynamic masks that must be ignored
        set_state(0, 0);
        set_state(1, 0);
        send(2'd3, 1'b1, 1'b0, 3'b100, 3'b100, 1'b1, 3'b011, 1'b0, "R6");
        // R11: config flipped after the strobe edge
        set_state(0, 4);
        set_state(1, 4);
        send(2'd2, 1'b0, 1'b0, 3'b000, 3'b111, 1'b0, 3'b000, 1'b1, "R11");
        set_state(0, 4);
        set_state(1, 4);
        // R1: back to idle, outputs zero
        @(negedge clk);
        check(dec_valid == 1'b0 && dec_mask == 3'b0 && dec_learn == 1'b0, "R1",
              "idle outputs", int'({dec_valid, dec_mask, dec_learn}), 0);
        check(sb_q.size() == 0, "R1", "pending decisions", sb_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule